// File: doc/BRIEF.md
# Raster Frame Capture Controller

This block digitizes one frame of raster video into a frame SRAM. A flash converter outside the block produces one 8-bit sample per clock. Separate pulses mark the start of each field and the start of each scan line. The block follows the line and pixel position and enables the converter only inside the active part of each line. For every sample taken it issues one write to the frame store, with an address it generates itself.

A capture begins when software raises a request. The block then asks for the memory bus, and it starts at the first field marker that arrives while the bus is granted. It writes `LINES` lines of `SAMPLES` one-byte samples each. At the default size this is 480 by 512, or 256 gray levels per pixel. When the frame ends, the block gives a single-cycle completion pulse and releases the bus.

Each line marker is followed by `LEAD` blanking cycles, and then the active window opens for at most `SAMPLES` cycles. The clock is the sample clock. One clock period covers one conversion plus one SRAM write, about 100 ns at the default resolution.

Top module: `frame_grab_ctrl`

## Requirements
- R1: After `cap_req` is sampled high in the idle state, `mem_req` is high from the next cycle. No write occurs and `adc_run` stays low until `mem_grant` is high together with a field marker.
- R2: Line markers that arrive before the starting field marker produce no writes. The first line marker after the starting field marker is line 0, and the lines that follow are numbered 1, 2 and so on.
- R3: After a line marker in cycle c, `adc_run` is high in cycles c+LEAD+1 through c+LEAD+SAMPLES, which is one converter enable per sample of the line.
- R4: A sample taken in cycle n is written in cycle n+1. In that cycle `mem_we` is high for exactly one cycle per sample, and `mem_wdata` equals the value `adc_data` held in cycle n.
- R5: The write address is line index × SAMPLES + pixel index, with pixel index 0 for the first sample of a line. No address reaches LINES × SAMPLES.
- R6: A line marker that arrives while a line's window is open closes that window after the current sample. The new line restarts at pixel 0, and no write goes past the cut line's own addresses.
- R7: A field marker during a capture sets the line count back to 0. The line marker that follows writes line 0 again.
- R8: `cap_done` is a one-cycle pulse that coincides with the final write. The final write is either the last sample of line LINES-1 or the last sample before a marker cuts line LINES-1 short. `mem_req` then falls, and no further writes occur until the next request.
- R9: While reset is held, and in the cycle after it is released, `mem_req`, `mem_we`, `adc_run` and `cap_done` are all low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Sample clock, one period per sample |
| rst_n | input | 1 | Synchronous active-low reset |
| cap_req | input | 1 | Request for one frame capture |
| mem_grant | input | 1 | Frame memory bus granted to this block |
| field_start | input | 1 | One-cycle pulse at each field start |
| line_start | input | 1 | One-cycle pulse at each line start |
| adc_data | input | SAMPLE_W | Converter output for the current sample |
| mem_req | output | 1 | Requests the frame memory bus |
| cap_done | output | 1 | One-cycle pulse when the frame is complete |
| adc_run | output | 1 | Converter enable, high inside the active window |
| mem_we | output | 1 | Frame SRAM write strobe |
| mem_addr | output | ADDR_W | Frame SRAM write address |
| mem_wdata | output | SAMPLE_W | Frame SRAM write data |

## Verification
The assertions check four things on every cycle:
- a write only happens while the bus is requested;
- pixels step by one inside a window and never pass the last column;
- addresses stay inside the frame;
- a field marker clears the line count, and the completion pulse never lasts two cycles.

Some properties can only be shown by the directed scenarios:
- that sample data lands at the correct address with the correct offset from its line marker;
- that a cut line leaves its tail unwritten;
- that a restarted field overwrites the earlier lines;
- that nothing is written without a grant or after completion.

// File: rtl/frame_grab_pkg.sv
// Shared types for the frame capture controller.
package frame_grab_pkg;

    // Capture handshake states.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_WAIT = 2'd1,
        ST_CAPT = 2'd2
    } cap_state_e;

endpackage

// File: rtl/frame_grab_seq.sv
// Capture handshake sequencer.
// Goes from idle to waiting on a request. It starts capturing at the first
// field marker seen while the memory grant is high, and it returns to idle
// with a one-cycle done pulse when the timing unit reports the frame end.
// Assumes mem_grant stays high for the whole capture once it is given.
module frame_grab_seq
    import frame_grab_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cap_req,
    input  logic mem_grant,
    input  logic field_start,
    input  logic frame_end,
    output logic capturing,
    output logic mem_req,
    output logic cap_done
);

    cap_state_e state;

    // State register and done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            cap_done <= 1'b0;
        end else begin
            cap_done <= 1'b0;
            case (state)
                ST_IDLE: if (cap_req) state <= ST_WAIT;
                ST_WAIT: if (mem_grant && field_start) state <= ST_CAPT;
                ST_CAPT: begin
                    if (frame_end) begin
                        state    <= ST_IDLE;
                        cap_done <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // The bus stays requested through the cycle of the final write.
    always_comb begin
        capturing = (state == ST_CAPT);
        mem_req   = (state != ST_IDLE) || cap_done;
    end

    // R8: the done pulse never lasts two cycles.
    assert_done_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        cap_done |=> !cap_done);

endmodule

// File: rtl/frame_grab_timing.sv
// Line and pixel position tracker.
// While enabled, a field marker clears the line count. Each line marker
// starts a blanking lead of LEAD cycles, after which the active window opens
// for up to SAMPLES cycles. A new line marker ends any lead or window early.
// Line markers beyond LINES are ignored. Assumes one sample per clock.
module frame_grab_timing #(
    parameter int LINES   = 480,
    parameter int SAMPLES = 512,
    parameter int LEAD    = 100,
    localparam int LINE_W = $clog2(LINES + 1),
    localparam int PIX_W  = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
    localparam int LEAD_W = (LEAD > 1) ? $clog2(LEAD) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              active,
    input  logic              field_start,
    input  logic              line_start,
    output logic              in_win,
    output logic [LINE_W-1:0] cur_line,
    output logic [PIX_W-1:0]  pix,
    output logic              frame_end
);

    logic [LINE_W-1:0] next_line;
    logic [LEAD_W-1:0] lead_cnt;
    logic              in_lead;
    logic              on_last;
    logic              last_pix;

    always_comb begin
        on_last  = (next_line == LINE_W'(LINES));
        last_pix = (pix == PIX_W'(SAMPLES - 1));
        // The frame ends on its last sample, or when a marker cuts the last line.
        frame_end = active && !field_start && on_last &&
                    ((in_win && last_pix) || (line_start && (in_win || in_lead)));
    end

    // Line counter, blanking lead and active window.
    always_ff @(posedge clk) begin
        if (!rst_n || !active) begin
            next_line <= '0;
            cur_line  <= '0;
            pix       <= '0;
            lead_cnt  <= '0;
            in_lead   <= 1'b0;
            in_win    <= 1'b0;
        end else if (field_start) begin
            next_line <= '0;
            in_lead   <= 1'b0;
            in_win    <= 1'b0;
        end else if (line_start) begin
            pix      <= '0;
            lead_cnt <= '0;
            if (!on_last) begin
                cur_line  <= next_line;
                next_line <= next_line + 1'b1;
                in_lead   <= (LEAD != 0);
                in_win    <= (LEAD == 0);
            end else begin
                in_lead <= 1'b0;
                in_win  <= 1'b0;
            end
        end else if (in_lead) begin
            lead_cnt <= lead_cnt + 1'b1;
            if (lead_cnt == LEAD_W'(LEAD - 1)) begin
                in_lead <= 1'b0;
                in_win  <= 1'b1;
            end
        end else if (in_win) begin
            if (last_pix) in_win <= 1'b0;
            else          pix    <= pix + 1'b1;
        end
    end

    // R6: the pixel index never passes the last column inside a window.
    assert_pix_in_range_R6: assert property (@(posedge clk) disable iff (!rst_n)
        in_win |-> (32'(pix) < SAMPLES));

    // R3: consecutive window cycles of one line step the pixel by one.
    assert_pix_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_win && $past(in_win) && !$past(line_start) && !$past(field_start))
        |-> (pix == $past(pix) + PIX_W'(1)));

    // R7: a field marker during capture clears the line count and the window.
    assert_field_restart_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active && field_start) |=> ((next_line == '0) && !in_win));

endmodule

// File: rtl/frame_grab_wport.sv
// Frame SRAM write port.
// Registers one write per window cycle. The address is line times SAMPLES
// plus pixel, and the data is the converter value of that cycle.
// Assumes the converter output is settled within the sample cycle.
module frame_grab_wport #(
    parameter int LINES    = 480,
    parameter int SAMPLES  = 512,
    parameter int SAMPLE_W = 8,
    localparam int LINE_W  = $clog2(LINES + 1),
    localparam int PIX_W   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1,
    localparam int FRAME_N = LINES * SAMPLES,
    localparam int ADDR_W  = $clog2(FRAME_N)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_win,
    input  logic [LINE_W-1:0]   cur_line,
    input  logic [PIX_W-1:0]    pix,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata
);

    // Write strobe, address and data registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mem_we    <= 1'b0;
            mem_addr  <= '0;
            mem_wdata <= '0;
        end else begin
            mem_we <= in_win;
            if (in_win) begin
                mem_addr  <= ADDR_W'(cur_line) * ADDR_W'(SAMPLES) + ADDR_W'(pix);
                mem_wdata <= adc_data;
            end
        end
    end

    // R5: every write lands inside the frame.
    assert_addr_in_frame_R5: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (32'(mem_addr) < FRAME_N));

endmodule

// File: rtl/frame_grab_ctrl.sv
// Raster frame capture controller, top level.
// Connects the handshake sequencer, the position tracker and the SRAM write
// port. Assumes the clock is the sample clock, and that the field and line
// markers are single-cycle pulses synchronous to it.
module frame_grab_ctrl #(
    parameter int LINES    = 480,
    parameter int SAMPLES  = 512,
    parameter int LEAD     = 100,
    parameter int SAMPLE_W = 8,
    localparam int ADDR_W  = $clog2(LINES * SAMPLES),
    localparam int LINE_W  = $clog2(LINES + 1),
    localparam int PIX_W   = (SAMPLES > 1) ? $clog2(SAMPLES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cap_req,
    input  logic                mem_grant,
    input  logic                field_start,
    input  logic                line_start,
    input  logic [SAMPLE_W-1:0] adc_data,
    output logic                mem_req,
    output logic                cap_done,
    output logic                adc_run,
    output logic                mem_we,
    output logic [ADDR_W-1:0]   mem_addr,
    output logic [SAMPLE_W-1:0] mem_wdata
);

    logic              capturing;
    logic              frame_end;
    logic              in_win;
    logic [LINE_W-1:0] cur_line;
    logic [PIX_W-1:0]  pix;

    frame_grab_seq u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_req     (cap_req),
        .mem_grant   (mem_grant),
        .field_start (field_start),
        .frame_end   (frame_end),
        .capturing   (capturing),
        .mem_req     (mem_req),
        .cap_done    (cap_done)
    );

    frame_grab_timing #(
        .LINES   (LINES),
        .SAMPLES (SAMPLES),
        .LEAD    (LEAD)
    ) u_timing (
        .clk         (clk),
        .rst_n       (rst_n),
        .active      (capturing),
        .field_start (field_start),
        .line_start  (line_start),
        .in_win      (in_win),
        .cur_line    (cur_line),
        .pix         (pix),
        .frame_end   (frame_end)
    );

    frame_grab_wport #(
        .LINES    (LINES),
        .SAMPLES  (SAMPLES),
        .SAMPLE_W (SAMPLE_W)
    ) u_wport (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_win    (in_win),
        .cur_line  (cur_line),
        .pix       (pix),
        .adc_data  (adc_data),
        .mem_we    (mem_we),
        .mem_addr  (mem_addr),
        .mem_wdata (mem_wdata)
    );

    // The converter is enabled exactly in the window cycles.
    always_comb adc_run = in_win;

    // R1: no write ever happens without the bus being requested.
    assert_we_has_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_req);

endmodule

// File: tb/frame_grab_ctrl_bench.sv
// Directed bench for the frame capture controller, at a reduced frame size.
module frame_grab_ctrl_bench;

    localparam int CLK_PERIOD = 10;
    localparam int LINES      = 3;
    localparam int SAMPLES    = 8;
    localparam int LEAD       = 2;
    localparam int GAP        = 3;
    localparam int FRAME_N    = LINES * SAMPLES;
    localparam int ADDR_W     = $clog2(FRAME_N);

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cap_req = 1'b0;
    logic              mem_grant = 1'b0;
    logic              field_start = 1'b0;
    logic              line_start = 1'b0;
    logic [7:0]        adc_data = '0;
    logic              mem_req;
    logic              cap_done;
    logic              adc_run;
    logic              mem_we;
    logic [ADDR_W-1:0] mem_addr;
    logic [7:0]        mem_wdata;

    int n_chk = 0;
    int n_err = 0;
    int cyc = 0;
    logic [7:0] prev_adc = '0;
    logic       prev_run = 1'b0;

    int         wr_cnt [FRAME_N];
    logic [7:0] shadow [FRAME_N];
    int wr_total = 0, run_cnt = 0, done_cnt = 0, done_bad = 0, r4_bad = 0, oob = 0;
    int line_c [LINES];

    frame_grab_ctrl #(
        .LINES   (LINES),
        .SAMPLES (SAMPLES),
        .LEAD    (LEAD)
    ) u_frame_grab_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cap_req     (cap_req),
        .mem_grant   (mem_grant),
        .field_start (field_start),
        .line_start  (line_start),
        .adc_data    (adc_data),
        .mem_req     (mem_req),
        .cap_done    (cap_done),
        .adc_run     (adc_run),
        .mem_we      (mem_we),
        .mem_addr    (mem_addr),
        .mem_wdata   (mem_wdata)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    function automatic logic [7:0] pat(int k);
        return 8'(k * 37 + 11);
    endfunction

    // Cycle count and previous-cycle converter values, taken at the edge.
    always @(posedge clk) begin
        cyc      <= cyc + 1;
        prev_adc <= adc_data;
        prev_run <= adc_run;
    end

    // Converter model: a known value in each cycle.
    always @(negedge clk) adc_data <= pat(cyc);

    // Write monitor, sampling outputs mid-cycle.
    always @(negedge clk) begin
        if (rst_n) begin
            if (mem_we) begin
                if (mem_wdata !== prev_adc || prev_run !== 1'b1) r4_bad++;
                if (32'(mem_addr) < FRAME_N) begin
                    wr_cnt[mem_addr]++;
                    shadow[mem_addr] = mem_wdata;
                end else oob++;
                wr_total++;
            end
            if (adc_run) run_cnt++;
            if (cap_done) begin
                done_cnt++;
                if (!mem_we) done_bad++;
            end
        end
    end

    // Watchdog: a hung run is a failed check.
    initial begin
        #(CLK_PERIOD * 20000);
        n_chk++; n_err++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        for (int i = 0; i < FRAME_N; i++) begin
            wr_cnt[i] = 0;
            shadow[i] = '0;
        end
        wr_total = 0; run_cnt = 0; done_cnt = 0; done_bad = 0; r4_bad = 0; oob = 0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_field();
        field_start = 1'b1;
        @(negedge clk);
        field_start = 1'b0;
    endtask

    // Issue a line marker and hold until the next marker for a cut after nsamp.
    task automatic drive_line(input int lidx, input int nsamp);
        int n;
        if (lidx >= 0 && lidx < LINES) line_c[lidx] = cyc;
        n = (nsamp >= SAMPLES) ? (LEAD + SAMPLES + GAP) : (LEAD + nsamp);
        line_start = 1'b1;
        repeat (n) begin
            @(negedge clk);
            line_start = 1'b0;
        end
    endtask

    // Compare one line of the shadow store with the expected data and counts.
    task automatic check_line(input int lidx, input int nsamp, input int cnt, input string req);
        int bad = 0, first_act = 0, first_exp = 0;
        for (int p = 0; p < SAMPLES; p++) begin
            int a = lidx * SAMPLES + p;
            int ec = (p < nsamp) ? cnt : 0;
            logic [7:0] ed = pat(line_c[lidx] + LEAD + 1 + p);
            if (wr_cnt[a] != ec || (ec != 0 && shadow[a] !== ed)) begin
                if (bad == 0) begin
                    first_act = (wr_cnt[a] != ec) ? wr_cnt[a] : int'(shadow[a]);
                    first_exp = (wr_cnt[a] != ec) ? ec : int'(ed);
                end
                bad++;
            end
        end
        chk(bad == 0, req, first_act, first_exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        idle(3);
        chk(mem_req == 1'b0 && mem_we == 1'b0, "R9 bus idle in reset", int'(mem_req), 0);
        chk(adc_run == 1'b0 && cap_done == 1'b0, "R9 run/done low in reset", int'(adc_run), 0);
        rst_n = 1'b1;
        idle(1);
        chk(mem_req == 1'b0 && mem_we == 1'b0 && adc_run == 1'b0 && cap_done == 1'b0,
            "R9 outputs low after reset", int'(mem_req), 0);
    endtask

    task automatic t_no_grant();
        clear_mon();
        cap_req = 1'b1;
        idle(1);
        chk(mem_req == 1'b1, "R1 mem_req after cap_req", int'(mem_req), 1);
        pulse_field();
        drive_line(-1, SAMPLES);
        chk(wr_total == 0 && run_cnt == 0, "R1 nothing before grant", wr_total + run_cnt, 0);
        mem_grant = 1'b1;
        drive_line(-1, SAMPLES);
        drive_line(-1, SAMPLES);
        chk(wr_total == 0 && run_cnt == 0, "R2 no capture before field marker", wr_total, 0);
    endtask

    task automatic t_full_frame();
        clear_mon();
        pulse_field();
        cap_req = 1'b0;
        for (int l = 0; l < LINES; l++) drive_line(l, SAMPLES);
        check_line(0, SAMPLES, 1, "R2 R5 line 0 data and address");
        check_line(1, SAMPLES, 1, "R3 R5 line 1 sample timing");
        check_line(LINES - 1, SAMPLES, 1, "R5 last line data and address");
        chk(run_cnt == FRAME_N, "R3 adc_run cycles", run_cnt, FRAME_N);
        chk(r4_bad == 0, "R4 write data follows sample", r4_bad, 0);
        chk(wr_total == FRAME_N && oob == 0, "R4 one write per sample", wr_total, FRAME_N);
        chk(done_cnt == 1, "R8 one done pulse", done_cnt, 1);
        chk(done_bad == 0, "R8 done with final write", done_bad, 0);
        chk(mem_req == 1'b0, "R8 bus released", int'(mem_req), 0);
        drive_line(-1, SAMPLES);
        pulse_field();
        drive_line(-1, SAMPLES);
        chk(wr_total == FRAME_N && done_cnt == 1, "R8 no writes after done", wr_total, FRAME_N);
    endtask

    task automatic t_short_lines();
        clear_mon();
        cap_req = 1'b1;
        idle(1);
        pulse_field();
        cap_req = 1'b0;
        drive_line(0, SAMPLES);
        drive_line(1, 5);
        drive_line(2, 3);
        drive_line(-1, SAMPLES);
        check_line(0, SAMPLES, 1, "R6 line before cut intact");
        check_line(1, 5, 1, "R6 cut line tail unwritten");
        check_line(2, 3, 1, "R6 cut last line");
        chk(wr_total == SAMPLES + 8 && oob == 0, "R6 write total with cuts", wr_total, SAMPLES + 8);
        chk(done_cnt == 1 && done_bad == 0, "R8 done on cut last line", done_cnt, 1);
        chk(r4_bad == 0, "R4 data on cut lines", r4_bad, 0);
    endtask

    task automatic t_field_restart();
        clear_mon();
        cap_req = 1'b1;
        idle(1);
        pulse_field();
        cap_req = 1'b0;
        drive_line(0, SAMPLES);
        drive_line(1, SAMPLES);
        pulse_field();
        for (int l = 0; l < LINES; l++) drive_line(l, SAMPLES);
        check_line(0, SAMPLES, 2, "R7 line 0 rewritten after field");
        check_line(1, SAMPLES, 2, "R7 line 1 rewritten after field");
        check_line(2, SAMPLES, 1, "R7 last line once");
        chk(done_cnt == 1 && done_bad == 0, "R7 single done after restart", done_cnt, 1);
        chk(mem_req == 1'b0, "R8 bus released after restart frame", int'(mem_req), 0);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_no_grant();
        t_full_frame();
        t_short_lines();
        t_field_restart();
        idle(2);
        $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
        $finish;
    end

endmodule